// File: doc/BRIEF.md
# Read-After-Write Interlock for an In-Order Five-Stage Pipeline

This block decides, every cycle, whether the instruction sitting in decode may move on to execute. The pipeline it serves has fetch, decode, execute, memory and writeback stages. The register file is written at the end of writeback and no result is forwarded, so a consumer must wait in decode until its producer has left writeback. The block keeps a short chain of destination tags, one for each stage from execute through writeback. Each cycle it compares both decode source fields against every tag in that chain.

When any live source matches a valid, register-writing tag, the block holds the program counter and the fetch/decode register by dropping their write enables. It also tells the pipeline to place an empty instruction into execute. Its own tag chain shifts forward on every clock, stall or not, so the producer drains and the hold ends without outside help. Register zero is hard-wired, so it never counts as a dependence. A source whose use flag is clear is ignored as well.

The number of tracked stages is the parameter `DEPTH`, which defaults to three (execute, memory, writeback). The register-field width comes from the shared package.

Top module: `raw_interlock`

## Requirements
- R1: While decode holds a valid instruction with its first-source use flag set and a nonzero first source that equals the destination of a valid, register-writing instruction in execute, memory or writeback, the block stalls.
- R2: The second source field is compared against the same three stages under its own use flag, independently of the first. A match on either source alone is enough to stall.
- R3: A source field equal to register 0 never causes a stall, even when a stage writes register 0.
- R4: A source whose use flag is 0 never causes a stall. A downstream instruction whose write flag is 0 never causes a stall.
- R5: During a stall, `pc_we` and `fd_we` are both 0 (both are active-high write enables), so the held instruction stays in decode. They are 1 in every cycle without a stall.
- R6: During a stall, `ex_bubble` is 1. On the next cycle the execute tag is invalid and non-writing, so the bubble can never match a later comparison. `ex_bubble` is 0 when there is no stall.
- R7: The tags advance one stage on every clock regardless of stalls. A consumer issued directly behind its producer stalls 3 cycles, one issued two behind stalls 2 cycles, one issued three behind stalls 1 cycle, and one issued four or more behind does not stall.
- R8: After a first consumer has waited out a producer, a second consumer of the same register that follows it directly does not stall.
- R9: An invalid decode slot (`id_valid` = 0) never stalls, whatever its source fields and use flags are.
- R10: Reset (synchronous, active high) clears every tracked stage to invalid, so the first cycle after reset has no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_src_a | input | 5 | First source register field |
| id_use_a | input | 1 | Instruction reads the first source |
| id_src_b | input | 5 | Second source register field |
| id_use_b | input | 1 | Instruction reads the second source |
| id_dest | input | 5 | Destination register of the decode instruction |
| id_wr | input | 1 | Decode instruction writes the register file |
| pc_we | output | 1 | Program counter write enable |
| fd_we | output | 1 | Fetch/decode register write enable |
| ex_bubble | output | 1 | Place an empty instruction into execute |

## Verification
The bench builds the block with the default `DEPTH` of 3 and a 5-bit register field. This matches the three-stage drain of the target pipeline, so the exact stall counts of 3, 2, 1 and 0 can be checked against programs where producer and consumer are one to four slots apart. Those programs also cover matches on the second source, register zero used on both sides, cleared use and write flags, invalid decode slots, and a pair of back-to-back consumers. In each cycle the bench's own issue history predicts the stall and compares it with all three outputs.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Register-field width of the register file
    localparam int RF_AW = 5;

    // One tracked downstream stage: does it hold an instruction that will write RF[dest]
    typedef struct packed {
        logic             valid;
        logic             wr;
        logic [RF_AW-1:0] dest;
    } stage_tag_t;

    localparam stage_tag_t EMPTY_TAG = '{valid: 1'b0, wr: 1'b0, dest: '0};

    // A source counts only for a valid instruction that reads it and when it is not register 0
    function automatic logic src_live(input logic vld, input logic use_flag,
                                      input logic [RF_AW-1:0] src);
        return vld && use_flag && (src != '0);
    endfunction

    // A stage can block a consumer only when it holds a real register writer
    function automatic logic tag_writes(input stage_tag_t t, input logic [RF_AW-1:0] src);
        return t.valid && t.wr && (t.dest == src);
    endfunction

endpackage

// File: rtl/hz_stage_track.sv
module hz_stage_track
    import hz_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  stage_tag_t             entry,
    output stage_tag_t [DEPTH-1:0] stg
);

    // stg[0] = execute, stg[DEPTH-1] = writeback; shifts on every clock
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                stg[k] <= EMPTY_TAG;
            end
        end else begin
            stg[0] <= entry;
            for (int k = 1; k < DEPTH; k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

endmodule

// File: rtl/hz_src_cmp.sv
module hz_src_cmp
    import hz_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                   live,
    input  logic [RF_AW-1:0]       src,
    input  stage_tag_t [DEPTH-1:0] stg,
    output logic [DEPTH-1:0]       hit
);

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        assign hit[k] = live && tag_writes(stg[k], src);
    end

endmodule

// File: rtl/hz_issue.sv
module hz_issue
    import hz_pkg::*;
(
    input  logic             stall,
    input  logic             id_valid,
    input  logic [RF_AW-1:0] id_dest,
    input  logic             id_wr,
    output stage_tag_t       entry,
    output logic             pc_we,
    output logic             fd_we,
    output logic             ex_bubble
);

    always_comb begin
        if (stall) begin
            entry = EMPTY_TAG;
        end else begin
            entry.valid = id_valid;
            entry.wr    = id_valid && id_wr;
            entry.dest  = id_dest;
        end
        pc_we     = !stall;
        fd_we     = !stall;
        ex_bubble = stall;
    end

endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
    import hz_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             id_valid,
    input  logic [RF_AW-1:0] id_src_a,
    input  logic             id_use_a,
    input  logic [RF_AW-1:0] id_src_b,
    input  logic             id_use_b,
    input  logic [RF_AW-1:0] id_dest,
    input  logic             id_wr,
    output logic             pc_we,
    output logic             fd_we,
    output logic             ex_bubble
);

    localparam int NSRC = 2;

    stage_tag_t [DEPTH-1:0] stg;
    stage_tag_t             entry;
    logic [NSRC-1:0][RF_AW-1:0] srcs;
    logic [NSRC-1:0]        live;
    logic [NSRC-1:0][DEPTH-1:0] hits;
    logic                   stall;

    // Flattened stage view for the checker
    logic [DEPTH-1:0]            stg_valid;
    logic [DEPTH-1:0]            stg_wr;
    logic [DEPTH-1:0][RF_AW-1:0] stg_dest;

    assign srcs[0] = id_src_a;
    assign srcs[1] = id_src_b;
    assign live[0] = src_live(id_valid, id_use_a, id_src_a);
    assign live[1] = src_live(id_valid, id_use_b, id_src_b);

    hz_stage_track #(.DEPTH(DEPTH)) u_track (
        .clk   (clk),
        .rst   (rst),
        .entry (entry),
        .stg   (stg)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        hz_src_cmp #(.DEPTH(DEPTH)) u_cmp (
            .live (live[s]),
            .src  (srcs[s]),
            .stg  (stg),
            .hit  (hits[s])
        );
    end

    assign stall = |hits;

    hz_issue u_issue (
        .stall     (stall),
        .id_valid  (id_valid),
        .id_dest   (id_dest),
        .id_wr     (id_wr),
        .entry     (entry),
        .pc_we     (pc_we),
        .fd_we     (fd_we),
        .ex_bubble (ex_bubble)
    );

    for (genvar k = 0; k < DEPTH; k++) begin : g_flat
        assign stg_valid[k] = stg[k].valid;
        assign stg_wr[k]    = stg[k].wr;
        assign stg_dest[k]  = stg[k].dest;
    end

endmodule

// File: rtl/raw_interlock_chk.sv
module raw_interlock_chk
    import hz_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        id_valid,
    input logic [RF_AW-1:0]            id_src_a,
    input logic                        id_use_a,
    input logic [RF_AW-1:0]            id_src_b,
    input logic                        id_use_b,
    input logic                        pc_we,
    input logic                        ex_bubble,
    input logic [DEPTH-1:0]            stg_valid,
    input logic [DEPTH-1:0]            stg_wr,
    input logic [DEPTH-1:0][RF_AW-1:0] stg_dest
);

    localparam int CW = $clog2(DEPTH + 2);

    logic [CW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (ex_bubble) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R3
    zero_src_chk: assert property (@(posedge clk) disable iff (rst)
        ((!id_use_a || id_src_a == '0) && (!id_use_b || id_src_b == '0)) |-> pc_we);

    // R9
    idle_dec_chk: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> pc_we);

    // R6
    bubble_inval_chk: assert property (@(posedge clk) disable iff (rst)
        ex_bubble |=> (!stg_valid[0] && !stg_wr[0]));

    // R7
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        ex_bubble |-> (run_len < CW'(DEPTH)));

    // R10
    post_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pc_we);

    for (genvar k = 1; k < DEPTH; k++) begin : g_adv
        // R7
        advance_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (stg_valid[k] == $past(stg_valid[k-1]) &&
                             stg_wr[k]    == $past(stg_wr[k-1]) &&
                             stg_dest[k]  == $past(stg_dest[k-1])));
    end

endmodule

bind raw_interlock raw_interlock_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .id_valid  (id_valid),
    .id_src_a  (id_src_a),
    .id_use_a  (id_use_a),
    .id_src_b  (id_src_b),
    .id_use_b  (id_use_b),
    .pc_we     (pc_we),
    .ex_bubble (ex_bubble),
    .stg_valid (stg_valid),
    .stg_wr    (stg_wr),
    .stg_dest  (stg_dest)
);

// File: tb/test_raw_interlock.sv
`timescale 1ns/1ps
module test_raw_interlock;

    localparam int DEPTH = 3;
    localparam int AW    = 5;
    localparam int MAXP  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          id_valid = 1'b0;
    logic [AW-1:0] id_src_a = '0;
    logic          id_use_a = 1'b0;
    logic [AW-1:0] id_src_b = '0;
    logic          id_use_b = 1'b0;
    logic [AW-1:0] id_dest  = '0;
    logic          id_wr    = 1'b0;
    logic          pc_we;
    logic          fd_we;
    logic          ex_bubble;

    always #2.5 clk = ~clk;

    raw_interlock #(.DEPTH(DEPTH)) i_raw_interlock (
        .clk       (clk),
        .rst       (rst),
        .id_valid  (id_valid),
        .id_src_a  (id_src_a),
        .id_use_a  (id_use_a),
        .id_src_b  (id_src_b),
        .id_use_b  (id_use_b),
        .id_dest   (id_dest),
        .id_wr     (id_wr),
        .pc_we     (pc_we),
        .fd_we     (fd_we),
        .ex_bubble (ex_bubble)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Program under test
    bit p_valid [MAXP];
    int p_sa [MAXP];
    bit p_ua [MAXP];
    int p_sb [MAXP];
    bit p_ub [MAXP];
    int p_dst [MAXP];
    bit p_wr [MAXP];
    int plen;

    // Reference history: issued instructions and the cycle they occupy execute
    int rq_ex[$];
    int rq_dest[$];
    bit rq_wr[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic bit ref_stall();
        bit hit = 1'b0;
        if (!id_valid) return 1'b0;
        for (int i = 0; i < rq_ex.size(); i++) begin
            int age = cyc - rq_ex[i];
            if (age >= 0 && age < DEPTH && rq_wr[i]) begin
                if (id_use_a && id_src_a != 0 && int'(id_src_a) == rq_dest[i]) hit = 1'b1;
                if (id_use_b && id_src_b != 0 && int'(id_src_b) == rq_dest[i]) hit = 1'b1;
            end
        end
        return hit;
    endfunction

    task automatic clear_prog();
        plen = 0;
    endtask

    task automatic add(input bit v, input int sa, input bit ua, input int sb, input bit ub,
                       input int dst, input bit wr);
        p_valid[plen] = v; p_sa[plen] = sa; p_ua[plen] = ua;
        p_sb[plen] = sb; p_ub[plen] = ub; p_dst[plen] = dst; p_wr[plen] = wr;
        plen++;
    endtask

    // filler: writes r7, reads nothing
    task automatic add_fill(input int n);
        for (int i = 0; i < n; i++) add(1, 0, 0, 0, 0, 7, 1);
    endtask

    // Runs the program through decode; returns the number of stall cycles seen
    task automatic run_prog(input string tag, output int stalls);
        int pc = 0;
        int tail = 0;
        stalls = 0;
        while (tail < DEPTH + 2) begin
            @(posedge clk);
            #1;
            if (pc < plen) begin
                id_valid = p_valid[pc]; id_src_a = AW'(p_sa[pc]); id_use_a = p_ua[pc];
                id_src_b = AW'(p_sb[pc]); id_use_b = p_ub[pc];
                id_dest = AW'(p_dst[pc]); id_wr = p_wr[pc];
            end else begin
                id_valid = 0; id_src_a = '0; id_use_a = 0; id_src_b = '0; id_use_b = 0;
                id_dest = '0; id_wr = 0;
                tail++;
            end
            @(negedge clk);
            begin
                bit es = ref_stall();
                // R5 R6: every cycle the three outputs follow the reference stall
                check(pc_we == !es && fd_we == !es, {"R5 ", tag}, int'(pc_we), int'(!es));
                check(ex_bubble == es, {"R6 ", tag}, int'(ex_bubble), int'(es));
                if (ex_bubble) stalls++;
                if (!es && pc < plen) begin
                    if (p_valid[pc]) begin
                        rq_ex.push_back(cyc + 1);
                        rq_dest.push_back(p_dst[pc]);
                        rq_wr.push_back(p_wr[pc]);
                    end
                    pc++;
                end
            end
        end
    endtask

    task automatic dist_case(input int d, input int exp, input string req);
        int s;
        clear_prog();
        add(1, 1, 1, 2, 1, 5, 1);
        add_fill(d - 1);
        add(1, 5, 1, 0, 0, 9, 1);
        run_prog(req, s);
        check(s == exp, req, s, exp);
    endtask

    initial begin
        int s;
        id_src_a = 5'd5; id_use_a = 1; id_valid = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R10: decode reads r5 right after reset, stages empty
        check(pc_we && fd_we && !ex_bubble, "R10 reset", int'(pc_we), 1);

        // R1 R7: distances 1..4 on the first source
        dist_case(1, 3, "R1 R7 dist1");
        dist_case(2, 2, "R7 dist2");
        dist_case(3, 1, "R7 dist3");
        dist_case(4, 0, "R7 dist4");

        // R2: second source only
        clear_prog();
        add(1, 1, 1, 2, 1, 6, 1);
        add(1, 3, 1, 6, 1, 9, 1);
        run_prog("R2", s);
        check(s == 3, "R2 src_b dist1", s, 3);

        // R2: second source at distance 2
        clear_prog();
        add(1, 1, 1, 2, 1, 6, 1);
        add_fill(1);
        add(1, 0, 0, 6, 1, 9, 1);
        run_prog("R2", s);
        check(s == 2, "R2 src_b dist2", s, 2);

        // R3: register 0 written and read
        clear_prog();
        add(1, 1, 1, 2, 1, 0, 1);
        add(1, 0, 1, 0, 1, 9, 1);
        run_prog("R3", s);
        check(s == 0, "R3 zero reg", s, 0);

        // R4: matching source with use flag clear
        clear_prog();
        add(1, 1, 1, 2, 1, 5, 1);
        add(1, 5, 0, 5, 0, 9, 1);
        run_prog("R4", s);
        check(s == 0, "R4 unused src", s, 0);

        // R4: producer that does not write
        clear_prog();
        add(1, 1, 1, 2, 1, 5, 0);
        add(1, 5, 1, 5, 1, 9, 1);
        run_prog("R4", s);
        check(s == 0, "R4 non-writer", s, 0);

        // R8: two consumers back to back
        clear_prog();
        add(1, 1, 1, 2, 1, 5, 1);
        add(1, 5, 1, 0, 0, 9, 1);
        add(1, 0, 0, 5, 1, 10, 1);
        run_prog("R8", s);
        check(s == 3, "R8 second consumer", s, 3);

        // R9: invalid slot with matching sources
        clear_prog();
        add(1, 1, 1, 2, 1, 5, 1);
        add(0, 5, 1, 5, 1, 9, 1);
        run_prog("R9", s);
        check(s == 0, "R9 invalid decode", s, 0);

        // R1: both sources depend on different producers
        clear_prog();
        add(1, 1, 1, 2, 1, 5, 1);
        add(1, 1, 1, 2, 1, 6, 1);
        add(1, 5, 1, 6, 1, 9, 1);
        run_prog("R1", s);
        check(s == 3, "R1 two producers", s, 3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule